// File: doc/BRIEF.md
# D-Channel Side Port Diverter

This block sits between a 2B+D serial bus and the transceiver core. When the side port is on, it takes the two D-channel bits of each frame off the main serial bus and routes them to a separate three-wire port. The port has its own data input, its own data output and a gated clock output. The block counts bit times from the receive frame strobe to find where the D bits fall. That position is either a fixed default or a timeslot that the caller programs. During those two bit times the main output is released, whatever the main input carries is discarded, and clock pulses appear on the side port.

Data arriving on the side-port input is captured in the D-bit times of one frame. It is handed to the core in the D slot of the following frame, so the core sees a complete, aligned D pair. The side port can be switched on only while the register bus is serial. A parallel-bus mode input forces it off at once.

Top module: `dch_port_diverter`

## Requirements
- R1: A hardware reset (`rst`) or a one-cycle software reset (`sw_rst_i`) clears the port enable. While the port is off, `dch_clk_o` and `dch_dout_o` stay low, `dout_oe_o` equals `core_doe_i`, and `core_din_o` equals `din_i`.
- R2: A cycle with `en_wr_i` high loads `en_wdata_i` into the port enable. The new value takes effect from the next bit onward. A software reset in the same cycle wins.
- R3: A rising clock edge that samples `fsr_i` high starts bit 0 of a frame. Each later edge advances the bit position by one. With `tsa_mode_i` low, the D bits are bits 16 (D1) and 17 (D2).
- R4: While the port is on, `dch_clk_o` follows the high phase of `clk` only during the two D bits, and it is low at every other time.
- R5: `dout_o` always carries `core_dout_i`. `dout_oe_o` is low during the D bits while the port is on, and otherwise equals `core_doe_i`.
- R6: While the port is on, the value of `din_i` during the D bits never reaches `core_din_o`. Outside the D bits, `core_din_o` equals `din_i`.
- R7: While the port is on, `dch_dout_o` carries `core_dout_i` during each D bit and holds the last D bit between slots. The block has no enable for this output, so it is never released.
- R8: `dch_din_i` is sampled at the edge that ends each D bit. The pair captured in one frame is given on `core_din_o` in the next frame's D slot, D1 first. After either reset the delivered pair is 1,1 and the held side output is 0.
- R9: With `tsa_mode_i` high, D1 falls at bit 2 × `ts_slot_i` and D2 at the bit after it, for every slot value from 0 to 31.
- R10: `par_bus_i` high forces the port off in the same cycle, without changing the stored enable.
- R11: After a hardware reset and before the first strobe, the bit position saturates, so no bit counts as a D bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus bit clock; one bit per period |
| rst | input | 1 | Synchronous active-high hardware reset |
| sw_rst_i | input | 1 | Software reset pulse; clears enable and buffer |
| en_wr_i | input | 1 | Enable write strobe |
| en_wdata_i | input | 1 | Enable value written |
| par_bus_i | input | 1 | Parallel register bus mode; forces port off |
| tsa_mode_i | input | 1 | Selects programmed timeslot for the D bits |
| ts_slot_i | input | TS_W | D-bit timeslot in units of two bits |
| fsr_i | input | 1 | Receive frame strobe marking bit 0 |
| core_dout_i | input | 1 | Serial data from core toward the bus |
| core_doe_i | input | 1 | Core request to drive the bus output |
| din_i | input | 1 | Main bus serial input |
| dch_din_i | input | 1 | Side-port data input |
| dout_o | output | 1 | Main bus serial output data |
| dout_oe_o | output | 1 | Main bus output enable; low means high impedance |
| core_din_o | output | 1 | Serial data to core |
| dch_clk_o | output | 1 | Gated side-port clock |
| dch_dout_o | output | 1 | Side-port data output |

## Verification
The bench drives frames with no strobe yet and short and long frames, and it moves the programmed slot to its lowest, a middle and its highest value. A position counter that wraps instead of saturating, or a slot base that is not doubled, would put the gated clock and the released output on the wrong bits.

It turns the enable off in the middle of a D slot, asserts a software reset inside a frame, and toggles parallel mode. A design that updated the clock gate late, or kept the enable through a software reset, would leave stray clock pulses or an output released on the main bus.

Random side-port data checked one frame later catches a buffer that swaps D1 and D2, delivers the pair in the same frame, or leaks main-input data into the D slot.

// File: rtl/dchp_pkg.sv
`timescale 1ns/1ps
package dchp_pkg;

    // Decoded position of the current bit against the D slot
    typedef struct packed {
        logic hit;   // bit is D1 or D2
        logic idx;   // 0 = D1, 1 = D2
    } dslot_t;

    // Pair of D bits held for the core
    typedef struct packed {
        logic d1;
        logic d2;
    } dpair_t;

    localparam dpair_t DPAIR_IDLE = '{d1: 1'b1, d2: 1'b1};

    function automatic int unsigned slot_base(input logic tsa,
                                              input int unsigned ts,
                                              input int unsigned def_pos);
        return tsa ? (2 * ts) : def_pos;
    endfunction

    function automatic dslot_t slot_decode(input int unsigned pos,
                                           input int unsigned base);
        dslot_t r;
        r.hit = (pos == base) || (pos == base + 1);
        r.idx = (pos == base + 1);
        return r;
    endfunction

endpackage

// File: rtl/dchp_timing.sv
`timescale 1ns/1ps
module dchp_timing
    import dchp_pkg::*;
#(
    parameter int unsigned POS_W   = 8,
    parameter int unsigned TS_W    = 5,
    parameter int unsigned DEF_POS = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            fsr_i,
    input  logic            tsa_mode_i,
    input  logic [TS_W-1:0] ts_slot_i,
    input  logic            on_now_i,
    input  logic            on_next_i,
    output dslot_t          slot_o,
    output logic            gate_o
);
    localparam int unsigned POS_MAX = (1 << POS_W) - 1;

    logic [POS_W-1:0] pos_q;
    logic [POS_W-1:0] pos_nx;
    int unsigned      base;
    dslot_t           cur;
    dslot_t           nxt;
    logic             gate_q;

    always_comb base = slot_base(tsa_mode_i, 32'(ts_slot_i), DEF_POS);

    // Saturating bit position; a strobe restarts it at zero
    always_comb begin
        if (fsr_i)
            pos_nx = '0;
        else if (pos_q == POS_W'(POS_MAX))
            pos_nx = pos_q;
        else
            pos_nx = pos_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            pos_q <= POS_W'(POS_MAX);
        else
            pos_q <= pos_nx;
    end

    always_comb begin
        cur = slot_decode(32'(pos_q), base);
        nxt = slot_decode(32'(pos_nx), base);
    end

    // Gate opened on the falling edge ahead of the bit, so the
    // AND with the bit clock never changes while the clock is high
    always_ff @(negedge clk) begin
        if (rst)
            gate_q <= 1'b0;
        else
            gate_q <= on_next_i & nxt.hit;
    end

    assign slot_o = '{hit: on_now_i & cur.hit, idx: cur.idx};
    assign gate_o = gate_q;

endmodule

// File: rtl/dchp_rxbuf.sv
`timescale 1ns/1ps
module dchp_rxbuf
    import dchp_pkg::*;
(
    input  logic   clk,
    input  logic   clr_i,
    input  logic   cap_i,
    input  logic   idx_i,
    input  logic   din_i,
    output dpair_t hold_o
);
    logic   stage_q;
    dpair_t hold_q;

    always_ff @(posedge clk) begin
        if (clr_i) begin
            stage_q <= 1'b1;
            hold_q  <= DPAIR_IDLE;
        end else if (cap_i) begin
            if (!idx_i)
                stage_q <= din_i;
            else
                hold_q <= '{d1: stage_q, d2: din_i};
        end
    end

    assign hold_o = hold_q;

endmodule

// File: rtl/dch_port_diverter.sv
`timescale 1ns/1ps
module dch_port_diverter
    import dchp_pkg::*;
#(
    parameter int unsigned POS_W   = 8,
    parameter int unsigned TS_W    = 5,
    parameter int unsigned DEF_POS = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            sw_rst_i,
    input  logic            en_wr_i,
    input  logic            en_wdata_i,
    input  logic            par_bus_i,
    input  logic            tsa_mode_i,
    input  logic [TS_W-1:0] ts_slot_i,
    input  logic            fsr_i,
    input  logic            core_dout_i,
    input  logic            core_doe_i,
    input  logic            din_i,
    input  logic            dch_din_i,
    output logic            dout_o,
    output logic            dout_oe_o,
    output logic            core_din_o,
    output logic            dch_clk_o,
    output logic            dch_dout_o
);
    logic   en_q;
    logic   en_nx;
    logic   on_now;
    logic   on_next;
    logic   clr;
    logic   last_q;
    logic   gate;
    dslot_t slot;
    dpair_t hold;

    assign clr = rst | sw_rst_i;

    always_comb begin
        en_nx = en_q;
        if (clr)
            en_nx = 1'b0;
        else if (en_wr_i)
            en_nx = en_wdata_i;
    end

    always_ff @(posedge clk) en_q <= en_nx;

    assign on_now  = en_q  & ~par_bus_i;
    assign on_next = en_nx & ~par_bus_i;

    dchp_timing #(
        .POS_W  (POS_W),
        .TS_W   (TS_W),
        .DEF_POS(DEF_POS)
    ) timing_i (
        .clk       (clk),
        .rst       (rst),
        .fsr_i     (fsr_i),
        .tsa_mode_i(tsa_mode_i),
        .ts_slot_i (ts_slot_i),
        .on_now_i  (on_now),
        .on_next_i (on_next),
        .slot_o    (slot),
        .gate_o    (gate)
    );

    dchp_rxbuf rxbuf_i (
        .clk   (clk),
        .clr_i (clr),
        .cap_i (slot.hit),
        .idx_i (slot.idx),
        .din_i (dch_din_i),
        .hold_o(hold)
    );

    always_ff @(posedge clk) begin
        if (clr)
            last_q <= 1'b0;
        else if (slot.hit)
            last_q <= core_dout_i;
    end

    assign dout_o     = core_dout_i;
    assign dout_oe_o  = core_doe_i & ~slot.hit;
    assign core_din_o = slot.hit ? (slot.idx ? hold.d2 : hold.d1) : din_i;
    assign dch_dout_o = on_now & (slot.hit ? core_dout_i : last_q);
    assign dch_clk_o  = clk & gate;

endmodule

// File: rtl/dch_port_diverter_chk.sv
`timescale 1ns/1ps
module dch_port_diverter_chk (
    input logic clk,
    input logic rst,
    input logic sw_rst_i,
    input logic en_wr_i,
    input logic en_wdata_i,
    input logic par_bus_i,
    input logic tsa_mode_i,
    input logic fsr_i,
    input logic core_doe_i,
    input logic din_i,
    input logic dout_oe_o,
    input logic core_din_o,
    input logic dch_dout_o
);
    assert_swreset_off_R1: assert property (@(posedge clk) disable iff (rst)
        sw_rst_i |=> (dch_dout_o == 1'b0 && dout_oe_o == core_doe_i));

    assert_write_off_R2: assert property (@(posedge clk) disable iff (rst)
        (en_wr_i && !en_wdata_i) |=> (dch_dout_o == 1'b0 && dout_oe_o == core_doe_i));

    assert_bit0_not_slot_R3: assert property (@(posedge clk) disable iff (rst)
        (fsr_i && !tsa_mode_i) |=> (tsa_mode_i || dout_oe_o == core_doe_i));

    assert_oe_only_released_R5: assert property (@(posedge clk) disable iff (rst)
        !core_doe_i |-> !dout_oe_o);

    assert_parallel_forces_off_R10: assert property (@(posedge clk) disable iff (rst)
        par_bus_i |-> (dch_dout_o == 1'b0 && dout_oe_o == core_doe_i && core_din_o == din_i));

endmodule

bind dch_port_diverter dch_port_diverter_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .sw_rst_i  (sw_rst_i),
    .en_wr_i   (en_wr_i),
    .en_wdata_i(en_wdata_i),
    .par_bus_i (par_bus_i),
    .tsa_mode_i(tsa_mode_i),
    .fsr_i     (fsr_i),
    .core_doe_i(core_doe_i),
    .din_i     (din_i),
    .dout_oe_o (dout_oe_o),
    .core_din_o(core_din_o),
    .dch_dout_o(dch_dout_o)
);

// File: tb/dch_port_diverter_tb_top.sv
`timescale 1ns/1ps
module dch_port_diverter_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sw_rst = 1'b0;
    logic       en_wr = 1'b0;
    logic       en_wd = 1'b0;
    logic       par = 1'b0;
    logic       tsa = 1'b0;
    logic [4:0] ts = '0;
    logic       fsr = 1'b0;
    logic       core_dout = 1'b0;
    logic       core_doe = 1'b1;
    logic       din = 1'b0;
    logic       dch_din = 1'b0;

    logic dout, dout_oe, core_din, dch_clk, dch_dout;

    int    n_chk = 0;
    int    n_fail = 0;
    string phase = "R1";

    // behavioural reference state
    bit m_en = 0;
    int m_pos = 255;
    bit m_stage = 1, m_h1 = 1, m_h2 = 1, m_last = 0;
    bit gq[$];

    always #10 clk = ~clk;

    dch_port_diverter dut_i (
        .clk        (clk),
        .rst        (rst),
        .sw_rst_i   (sw_rst),
        .en_wr_i    (en_wr),
        .en_wdata_i (en_wd),
        .par_bus_i  (par),
        .tsa_mode_i (tsa),
        .ts_slot_i  (ts),
        .fsr_i      (fsr),
        .core_dout_i(core_dout),
        .core_doe_i (core_doe),
        .din_i      (din),
        .dch_din_i  (dch_din),
        .dout_o     (dout),
        .dout_oe_o  (dout_oe),
        .core_din_o (core_din),
        .dch_clk_o  (dch_clk),
        .dch_dout_o (dch_dout)
    );

    function automatic int base_now();
        return tsa ? 2 * int'(ts) : 16;
    endfunction

    task automatic chk(input string req, input string nm, input logic act, input bit exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s/%s %s: actual %b expected %b at %0t", phase, req, nm, act, exp, $time);
        end
    endtask

    task automatic model_edge();
        bit on;
        bit hit;
        int b;
        on  = m_en && !par;
        b   = base_now();
        hit = on && (m_pos == b || m_pos == b + 1);
        if (rst || sw_rst) begin
            m_stage = 1; m_h1 = 1; m_h2 = 1; m_last = 0;
        end else if (hit) begin
            m_last = core_dout;
            if (m_pos == b) m_stage = dch_din;
            else begin m_h1 = m_stage; m_h2 = dch_din; end
        end
        if (rst || sw_rst) m_en = 0;
        else if (en_wr)    m_en = en_wd;
        if (rst)      m_pos = 255;
        else if (fsr) m_pos = 0;
        else if (m_pos < 255) m_pos = m_pos + 1;
    endtask

    task automatic step();
        bit en_n;
        int pos_n;
        int b;
        bit on;
        bit hit;
        bit g;
        // expected gate for the coming bit, from the inputs now applied
        en_n  = (rst || sw_rst) ? 1'b0 : (en_wr ? en_wd : m_en);
        pos_n = rst ? 255 : (fsr ? 0 : (m_pos < 255 ? m_pos + 1 : 255));
        b     = base_now();
        gq.push_back(!rst && en_n && !par && (pos_n == b || pos_n == b + 1));
        @(posedge clk);
        model_edge();
        #5;
        g   = gq.pop_front();
        on  = m_en && !par;
        b   = base_now();
        hit = on && (m_pos == b || m_pos == b + 1);
        chk(tsa ? "R9" : "R4", "dch_clk", dch_clk, g);
        chk("R5", "dout_oe", dout_oe, core_doe && !hit);
        chk("R5", "dout", dout, core_dout);
        chk(hit ? "R8" : "R6", "core_din", core_din,
            hit ? ((m_pos == b) ? m_h1 : m_h2) : din);
        chk(on ? "R7" : "R10", "dch_dout", dch_dout,
            on ? (hit ? core_dout : m_last) : 1'b0);
    endtask

    task automatic rand_data();
        core_dout = 1'($urandom);
        core_doe  = ($urandom % 4) != 0;
        din       = 1'($urandom);
        dch_din   = 1'($urandom);
    endtask

    task automatic run_frames(input int nf, input int flen, input int wr_at, input bit wr_val);
        for (int f = 0; f < nf; f++) begin
            for (int b = 0; b < flen; b++) begin
                fsr   = (b == 0);
                en_wr = (f == 0 && b == wr_at);
                en_wd = wr_val;
                rand_data();
                step();
            end
        end
        en_wr = 0;
        fsr   = 0;
    endtask

    initial begin
        #4_000_000;
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        // R1: reset state
        phase = "R1";
        for (int i = 0; i < 3; i++) step();
        rst = 0;
        step();

        // R11 with R2: enable written, no strobe yet, position saturated
        phase = "R11";
        en_wr = 1; en_wd = 1;
        rand_data();
        step();
        en_wr = 0;
        for (int i = 0; i < 40; i++) begin rand_data(); step(); end

        // R3: default D position at bits 16/17
        phase = "R3";
        run_frames(6, 32, -1, 1'b0);

        // R8: buffered pair delivered in following frame
        phase = "R8";
        run_frames(4, 24, -1, 1'b0);

        // R9: programmed timeslot at low, middle and top values
        phase = "R9";
        tsa = 1; ts = 5'd0;
        run_frames(3, 32, -1, 1'b0);
        ts = 5'd5;
        run_frames(3, 32, -1, 1'b0);
        ts = 5'd31;
        run_frames(3, 64, -1, 1'b0);
        tsa = 0; ts = 5'd0;

        // R10: parallel-bus mode forces the port off
        phase = "R10";
        run_frames(1, 32, -1, 1'b0);
        par = 1;
        run_frames(2, 32, -1, 1'b0);
        par = 0;
        run_frames(2, 32, -1, 1'b0);

        // R1: software reset inside a frame, then stay disabled
        phase = "R1";
        for (int b = 0; b < 10; b++) begin
            fsr = (b == 0); sw_rst = (b == 9); rand_data(); step();
        end
        sw_rst = 0; fsr = 0;
        run_frames(2, 32, -1, 1'b0);

        // R2: re-enable, then disable in the middle of the D slot
        phase = "R2";
        run_frames(1, 32, 3, 1'b1);
        run_frames(2, 32, -1, 1'b0);
        run_frames(1, 32, 16, 1'b0);
        run_frames(1, 32, -1, 1'b0);
        run_frames(1, 32, 17, 1'b1);
        run_frames(3, 32, -1, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule